// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Collector

This block gathers up to 64 level-sensitive interrupt request lines and drives one interrupt output to the processor. Each source has three settings: a priority level, an enable bit and a software-trigger bit. From the sources that are pending, the block selects a winner. It reports the winner's number and a vector address, which is a programmable base plus four times the source number.

The block records which priority levels are currently being serviced. A source whose level is above every level in service can preempt the running handler. A control bit turns this nesting off, so that only one level is serviced at a time. A level goes in service when software writes the vector register. If the read-trigger control bit is set, reading the vector register does this instead. Software ends the service of a level by writing a one to that level's bit in the level-acknowledge register.

Registers are reached over a single-cycle bus. Read data is combinational on the address. Each register occupies 16 bytes, and address bits [3:2] select the operation: plain write, set bits, clear bits or toggle bits.

Top module: `irq_collector`

## Requirements
- R1: After reset, all source settings, the control register, the vector base and the in-service flags are zero. `irq_out` is low and the status register reads 0.
- R2: A source is pending when its enable bit is set and either its request line is high or its software-trigger bit is set. A disabled source is never pending, whatever its request line or trigger bit.
- R3: Among pending sources, the highest priority level wins, and the lowest source number breaks ties. The status register at 0x30 returns the winner's number in bits [5:0], or 0 when nothing is pending.
- R4: A read of the vector register at 0x00 returns the vector base plus 4 times the status number. The vector base register at 0x160 stores bits [31:2] only; bits [1:0] read as 0.
- R5: Address bits [3:2] select the write operation. 0 writes the data, 1 ORs the data into the register, 2 clears the bits that are set in the data, and 3 inverts the bits that are set in the data.
- R6: Source n is configured in the word at 0x60 + (n>>2)*0x10, in the byte that starts at bit (n&3)*8. In that byte, bits [1:0] hold the priority, bit 2 is the enable and bit 3 is the software trigger. Bits [7:4] read as 0.
- R7: When control bit 18 is 0, a write to the vector register puts the winner's level in service. A read of any register leaves the in-service flags unchanged.
- R8: When control bit 18 is 1, a read of the vector register puts the winner's level in service, and a write to the vector register has no effect.
- R9: Writing a 1 to bit k of the level-acknowledge register at 0x10 takes level k out of service. A read of 0x10 returns the in-service flags, one bit per level.
- R10: With nesting enabled, `irq_out` is high only when the winner's level is above the highest level in service.
- R11: When control bit 19 is 1, nesting is disabled and `irq_out` stays low whenever any level is in service.
- R12: Control bit 16 gates `irq_out`. While it is 0, the output is low. Control bits 19, 18 and 16 read back at 0x20, and all other bits of that register read as 0.
- R13: The register at 0x40 shows request lines 0 to 31 and the register at 0x50 shows lines 32 to 63, without any masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Level-sensitive request lines |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong in-service flag appears at the ports on the next cycle. Reading 0x10 shows the flag directly, and `irq_out` either stays low when a preempting source should fire or fires when the source should be masked. Arbitration faults show up in the same cycle as a wrong status number or vector address. The directed tests therefore read the acknowledge register and sample `irq_out` after each in-service trigger and after each acknowledge. They cover both trigger modes and both nesting settings.

// File: rtl/ic_pkg.sv
package ic_pkg;
   typedef enum logic [1:0] {
      OP_PLAIN = 2'd0,
      OP_SET   = 2'd1,
      OP_CLR   = 2'd2,
      OP_TGL   = 2'd3
   } ic_op_e;

   // word indices (byte address >> 4)
   localparam int IC_W_VECTOR = 0;
   localparam int IC_W_LVLACK = 1;
   localparam int IC_W_CTRL   = 2;
   localparam int IC_W_STAT   = 3;
   localparam int IC_W_RAW0   = 4;
   localparam int IC_W_RAW1   = 5;
   localparam int IC_W_SRC0   = 6;

   // control bit positions
   localparam int IC_C_IRQ_EN  = 16;
   localparam int IC_C_RD_SVC  = 18;
   localparam int IC_C_NO_NEST = 19;

   function automatic logic [31:0] ic_apply(input logic [31:0] old,
                                            input logic [31:0] wd,
                                            input ic_op_e op);
      case (op)
         OP_PLAIN: return wd;
         OP_SET:   return old | wd;
         OP_CLR:   return old & ~wd;
         default:  return old ^ wd;
      endcase
   endfunction
endpackage

// File: rtl/ic_arbiter.sv
module ic_arbiter #(
   parameter int NSRC   = 64,
   parameter int PRIO_W = 2,
   localparam int SRC_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]        pend,
   input  logic [NSRC*PRIO_W-1:0] prio_flat,
   output logic                   win_valid,
   output logic [SRC_W-1:0]       win_src,
   output logic [PRIO_W-1:0]      win_lvl
);
   always_comb begin
      win_valid = 1'b0;
      win_src   = '0;
      win_lvl   = '0;
      for (int i = 0; i < NSRC; i++) begin
         // strict compare keeps the lowest index on equal levels
         if (pend[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] > win_lvl)) begin
            win_valid = 1'b1;
            win_src   = SRC_W'(i);
            win_lvl   = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/ic_levels.sv
module ic_levels #(
   parameter int PRIO_W = 2,
   localparam int NLVL  = 1 << PRIO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter,
   input  logic [PRIO_W-1:0] enter_lvl,
   input  logic [NLVL-1:0]   ack_mask,
   input  logic              no_nest,
   input  logic              irq_en,
   input  logic              win_valid,
   input  logic [PRIO_W-1:0] win_lvl,
   output logic [NLVL-1:0]   inserv,
   output logic              irq
);
   logic [NLVL-1:0]   set_mask;
   logic [PRIO_W-1:0] hi_lvl;
   logic              any_srv;

   always_comb begin
      set_mask = '0;
      if (enter) set_mask[enter_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inserv <= '0;
      else        inserv <= (inserv & ~ack_mask) | set_mask;
   end

   always_comb begin
      hi_lvl = '0;
      for (int k = 0; k < NLVL; k++)
         if (inserv[k]) hi_lvl = PRIO_W'(k);
   end
   assign any_srv = |inserv;

   generate
      if (NLVL == 2) begin : g_two
         assign irq = irq_en && win_valid &&
                      (!any_srv || (!no_nest && win_lvl[0] && !inserv[1]));
      end else begin : g_many
         assign irq = irq_en && win_valid &&
                      (!any_srv || (!no_nest && win_lvl > hi_lvl));
      end
   endgenerate
endmodule

// File: rtl/irq_collector.sv
module irq_collector
   import ic_pkg::*;
#(
   parameter int NSRC   = 64,
   parameter int PRIO_W = 2,
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_req,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_out
);
   localparam int SRC_W   = $clog2(NSRC);
   localparam int NLVL    = 1 << PRIO_W;
   localparam int CFG_W   = PRIO_W + 2;
   localparam int NWORDS  = (NSRC + 3) / 4;
   localparam int W_VBASE = IC_W_SRC0 + NWORDS;
   localparam int IDX_W   = ADDR_W - 4;

   generate
      if (NSRC < 2 || NSRC > 64) begin : g_bad_nsrc
         $error("NSRC must lie in 2..64");
      end
      if (CFG_W > 8) begin : g_bad_prio
         $error("PRIO_W too wide for a byte lane");
      end
      if ((W_VBASE + 1) * 16 > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   // register state
   logic [PRIO_W-1:0] prio_q [NSRC];
   logic [NSRC-1:0]   en_q, soft_q;
   logic [31:2]       vbase_q;
   logic              irq_en_q, rd_svc_q, no_nest_q;
   logic [NLVL-1:0]   inserv_q;

   // decode
   logic [IDX_W-1:0] idx;
   ic_op_e           op;
   logic             wr_en, rd_en, hit_vec, hit_ack;
   assign idx     = bus_addr[ADDR_W-1:4];
   assign op      = ic_op_e'(bus_addr[3:2]);
   assign wr_en   = bus_sel && bus_wr;
   assign rd_en   = bus_sel && !bus_wr;
   assign hit_vec = (int'(idx) == IC_W_VECTOR);
   assign hit_ack = (int'(idx) == IC_W_LVLACK);

   // arbitration
   logic [NSRC-1:0]        pend;
   logic [NSRC*PRIO_W-1:0] prio_flat;
   logic                   win_valid;
   logic [SRC_W-1:0]       win_src;
   logic [PRIO_W-1:0]      win_lvl;

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_flat
         assign prio_flat[gi*PRIO_W +: PRIO_W] = prio_q[gi];
      end
   endgenerate
   assign pend = en_q & (irq_req | soft_q);

   ic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
      .pend      (pend),
      .prio_flat (prio_flat),
      .win_valid (win_valid),
      .win_src   (win_src),
      .win_lvl   (win_lvl)
   );

   // in-service tracking
   logic            enter;
   logic [NLVL-1:0] ack_mask;
   assign enter    = win_valid && hit_vec && (rd_svc_q ? rd_en : wr_en);
   assign ack_mask = (wr_en && hit_ack) ? bus_wdata[NLVL-1:0] : '0;

   ic_levels #(.PRIO_W(PRIO_W)) u_lvl (
      .clk       (clk),
      .rst_n     (rst_n),
      .enter     (enter),
      .enter_lvl (win_lvl),
      .ack_mask  (ack_mask),
      .no_nest   (no_nest_q),
      .irq_en    (irq_en_q),
      .win_valid (win_valid),
      .win_lvl   (win_lvl),
      .inserv    (inserv_q),
      .irq       (irq_out)
   );

   // read mux
   logic [63:0] raw_ext;
   logic [31:0] src_word, rd_word, wval;
   int          sw_idx;
   assign sw_idx = int'(idx) - IC_W_SRC0;

   always_comb begin
      raw_ext = '0;
      raw_ext[NSRC-1:0] = irq_req;
   end

   always_comb begin
      src_word = '0;
      for (int i = 0; i < NSRC; i++)
         if (i / 4 == sw_idx)
            src_word[(i % 4) * 8 +: CFG_W] = {soft_q[i], en_q[i], prio_q[i]};
   end

   always_comb begin
      rd_word = '0;
      case (int'(idx))
         IC_W_VECTOR: rd_word = {vbase_q, 2'b00} + (32'(win_src) << 2);
         IC_W_LVLACK: rd_word[NLVL-1:0] = inserv_q;
         IC_W_CTRL: begin
            rd_word[IC_C_IRQ_EN]  = irq_en_q;
            rd_word[IC_C_RD_SVC]  = rd_svc_q;
            rd_word[IC_C_NO_NEST] = no_nest_q;
         end
         IC_W_STAT:   rd_word[SRC_W-1:0] = win_src;
         IC_W_RAW0:   rd_word = raw_ext[31:0];
         IC_W_RAW1:   rd_word = raw_ext[63:32];
         W_VBASE:     rd_word = {vbase_q, 2'b00};
         default:     if (sw_idx >= 0 && sw_idx < NWORDS) rd_word = src_word;
      endcase
   end
   assign bus_rdata = rd_word;
   assign wval      = ic_apply(rd_word, bus_wdata, op);

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en_q  <= 1'b0;
         rd_svc_q  <= 1'b0;
         no_nest_q <= 1'b0;
         vbase_q   <= '0;
         en_q      <= '0;
         soft_q    <= '0;
         for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      end else if (wr_en) begin
         if (int'(idx) == IC_W_CTRL) begin
            irq_en_q  <= wval[IC_C_IRQ_EN];
            rd_svc_q  <= wval[IC_C_RD_SVC];
            no_nest_q <= wval[IC_C_NO_NEST];
         end
         if (int'(idx) == W_VBASE) vbase_q <= wval[31:2];
         for (int i = 0; i < NSRC; i++)
            if (i / 4 == sw_idx)
               {soft_q[i], en_q[i], prio_q[i]} <= wval[(i % 4) * 8 +: CFG_W];
      end
   end
endmodule

// File: rtl/ic_checker.sv
module ic_checker #(
   parameter int PRIO_W = 2,
   parameter int ADDR_W = 9,
   localparam int NLVL  = 1 << PRIO_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              irq_out,
   input logic [NLVL-1:0]   inserv,
   input logic              win_valid,
   input logic [PRIO_W-1:0] win_lvl,
   input logic              rd_svc,
   input logic              no_nest,
   input logic              irq_en
);
   logic vec_acc, ack_acc;
   assign vec_acc = bus_sel && (bus_addr[ADDR_W-1:4] == '0);
   assign ack_acc = bus_sel && bus_wr && (bus_addr[ADDR_W-1:4] == 1);

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> $stable(inserv));

   assert_vec_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_acc && !bus_wr) |-> (bus_rdata[1:0] == 2'b00));

   assert_wr_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_acc && bus_wr && !rd_svc && win_valid) |=> inserv[$past(win_lvl)]);

   assert_rd_noeffect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !rd_svc) |=> $stable(inserv));

   assert_rd_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_acc && !bus_wr && rd_svc && win_valid) |=> inserv[$past(win_lvl)]);

   assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_acc |=> ((inserv & $past(bus_wdata[NLVL-1:0])) == '0));

   assert_preempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !no_nest) |-> ((inserv >> win_lvl) == '0));

   assert_no_nest_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (no_nest && (|inserv)) |-> !irq_out);

   assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq_out);
endmodule

bind irq_collector ic_checker #(.PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .inserv    (inserv_q),
   .win_valid (win_valid),
   .win_lvl   (win_lvl),
   .rd_svc    (rd_svc_q),
   .no_nest   (no_nest_q),
   .irq_en    (irq_en_q)
);

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_req = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_collector #(.NSRC(NSRC), .PRIO_W(2), .ADDR_W(9)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
      #1;
   endtask

   task automatic rchk(input string tag, input logic [8:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   task automatic t_reset;
      check("R1 irq_out", 32'(irq_out), 0);
      rchk("R1 ctrl", 9'h020, 0);
      rchk("R1 stat", 9'h030, 0);
      rchk("R1 inserv", 9'h010, 0);
      rchk("R1 vbase", 9'h160, 0);
      rchk("R1 src word", 9'h060, 0);
   endtask

   task automatic t_raw;
      irq_req = 64'hA5A5_0001_8000_00F0;
      #1;
      rchk("R13 raw low", 9'h040, 32'h8000_00F0);
      rchk("R13 raw high", 9'h050, 32'hA5A5_0001);
      irq_req = '0;
   endtask

   task automatic t_alias;
      wr(9'h070, 32'h0000_0700);
      rchk("R6 plain", 9'h070, 32'h0000_0700);
      wr(9'h074, 32'h0000_0008);
      rchk("R5 set", 9'h070, 32'h0000_0708);
      wr(9'h078, 32'h0000_0100);
      rchk("R5 clear", 9'h070, 32'h0000_0608);
      wr(9'h07C, 32'h0000_0F00);
      rchk("R5 toggle", 9'h070, 32'h0000_0908);
      wr(9'h080, 32'hFFFF_FFFF);
      rchk("R6 upper nibble zero", 9'h080, 32'h0F0F_0F0F);
      wr(9'h070, 0);
      wr(9'h080, 0);
   endtask

   task automatic t_arb;
      wr(9'h160, 32'h0000_1003);
      rchk("R4 vbase low bits", 9'h160, 32'h0000_1000);
      wr(9'h024, 32'h0001_0000);
      irq_req[20] = 1'b1;
      #1 check("R2 disabled source", 32'(irq_out), 0);
      wr(9'h080, 32'h0005_0000);          // src10 prio1 en
      wr(9'h100, 32'h0000_0606);          // src40,41 prio2 en
      irq_req[10] = 1'b1; irq_req[40] = 1'b1; irq_req[41] = 1'b1;
      #1;
      rchk("R3 tie lowest", 9'h030, 40);
      rchk("R4 vector", 9'h000, 32'h0000_10A0);
      check("R3 irq", 32'(irq_out), 1);
      irq_req[40] = 1'b0;
      #1;
      rchk("R3 next", 9'h030, 41);
      wr(9'h064, 32'h0F00_0000);          // src3 prio3 en soft
      rchk("R2 soft trigger", 9'h030, 3);
      wr(9'h068, 32'h0400_0000);
      rchk("R2 disabled soft", 9'h030, 41);
      wr(9'h068, 32'h0800_0000);
   endtask

   task automatic t_nest;
      logic [31:0] d;
      rd(9'h000, d);
      rchk("R7 read no effect", 9'h010, 0);
      check("R7 irq after read", 32'(irq_out), 1);
      wr(9'h000, 0);
      rchk("R7 write enters", 9'h010, 32'h4);
      check("R10 same level blocked", 32'(irq_out), 0);
      wr(9'h064, 32'h0C00_0000);          // src3 prio3 pending
      check("R10 preempt", 32'(irq_out), 1);
      wr(9'h000, 0);
      rchk("R10 nested", 9'h010, 32'hC);
      check("R10 irq nested", 32'(irq_out), 0);
      wr(9'h010, 32'h8);
      rchk("R9 ack level3", 9'h010, 32'h4);
      check("R9 irq refire", 32'(irq_out), 1);
      wr(9'h068, 32'h0C00_0000);
      check("R10 lower blocked", 32'(irq_out), 0);
      wr(9'h010, 32'h4);
      rchk("R9 ack level2", 9'h010, 0);
      check("R9 irq after ack", 32'(irq_out), 1);
   endtask

   task automatic t_nonest;
      logic [31:0] d;
      wr(9'h024, 32'h000C_0000);
      rchk("R12 ctrl read", 9'h020, 32'h000D_0000);
      check("R11 idle irq", 32'(irq_out), 1);
      wr(9'h000, 0);
      rchk("R8 write ignored", 9'h010, 0);
      rd(9'h000, d);
      check("R8 vector value", d, 32'h0000_10A4);
      rchk("R8 read enters", 9'h010, 32'h4);
      wr(9'h064, 32'h0C00_0000);
      check("R11 no preempt", 32'(irq_out), 0);
      wr(9'h028, 32'h0008_0000);
      check("R10 nesting back", 32'(irq_out), 1);
      rd(9'h000, d);
      rchk("R8 nested read", 9'h010, 32'hC);
      wr(9'h010, 32'hF);
      rchk("R9 ack all", 9'h010, 0);
   endtask

   task automatic t_gate;
      check("R12 before gate", 32'(irq_out), 1);
      wr(9'h028, 32'h0001_0000);
      check("R12 gated", 32'(irq_out), 0);
      wr(9'h02C, 32'h0001_0000);
      check("R12 toggled on", 32'(irq_out), 1);
      rchk("R12 ctrl", 9'h020, 32'h0005_0000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_raw();
      t_alias();
      t_arb();
      t_nest();
      t_nonest();
      t_gate();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule